// File: doc/BRIEF.md
# BCD Calendar with Alarm Match

This block keeps the time-of-day and calendar registers of a real-time clock: seconds, minutes, hours, day of week, day of month, month, two-digit year and century. A one-cycle update strobe, issued once per second by the divider chain outside the block, advances the time by one second. All carries are applied in that single step, from seconds through minutes, hours, day, month and year up to the century.

Each register byte is held either as packed BCD or as plain binary. A format input selects which. The hour byte follows a 12-hour or a 24-hour convention. A host writes any field through a small address/data port, and a hold input freezes the calendar so that a new time can be loaded without racing the update. Three alarm bytes, for seconds, minutes and hours, are compared with the freshly advanced time. An alarm byte acts as a wildcard when its two top bits are both 1. The block emits a one-cycle update-ended pulse for every update it performs, and an alarm pulse alongside it on a match.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time bytes read seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, day of month 0x01, month 0x01, year 0x00 and century 0x20. The three alarm bytes reset to 0x00, and both pulse outputs are low.
- R2: With `binMode`=0 every byte is packed BCD, with tens in bits 7:4 and units in bits 3:0. With `binMode`=1 it is a plain binary value. Seconds 9 therefore advance to 0x10 in BCD and to 0x0A in binary.
- R3: Seconds count 0 to 59 and wrap to 0 with a carry into minutes. Minutes wrap the same way with a carry into hours.
- R4: With `hr24`=1 hours count 0 to 23 and wrap to 0 with a carry into the day. With `hr24`=0 bit 7 of the hour byte is the PM flag and bits 6:0 hold 12, 1, 2 … 11, so midnight reads 12 with bit 7 clear and noon reads 12 with bit 7 set. In BCD, 11 AM advances to 0x92, 12 PM advances to 0x81, and 11 PM advances to 0x12 with a day carry.
- R5: Day of month wraps to 1 after day 30 for months 4, 6, 9 and 11, and after day 31 for the other months. February has 29 days when the year value is divisible by 4 and 28 days otherwise. The wrap carries into the month.
- R6: On a day carry, day of week steps from 1 to 7 and then back to 1. Month steps from 12 back to 1 with a carry into the year. The year steps from 99 to 0 with a carry into the century, and the century also counts 0 to 99.
- R7: While `holdSet`=1 the update strobe is ignored: the time bytes do not change and neither pulse is raised. A host write made during the hold is kept exactly as written.
- R8: Each update that is performed raises `ufPulse` for exactly the one cycle after the clock edge that sampled the strobe, with the advanced time visible in that same cycle.
- R9: `afPulse` rises together with `ufPulse` when, for each of the seconds, minutes and hours alarm bytes, the byte either has bits 7:6 equal to 2'b11 or equals the advanced time byte of that field.
- R10: A host write in the same cycle as the update strobe wins. The written byte is stored, the strobe is dropped, no other field changes and no pulse is raised.
- R11: `wrAddr` selects the field: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 century, 8 alarm seconds, 9 alarm minutes, 10 alarm hours. A write to addresses 11 to 15 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tickStrobe | input | 1 | One-second update request, one cycle wide |
| binMode | input | 1 | 1 = binary bytes, 0 = packed BCD |
| hr24 | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM in bit 7 |
| holdSet | input | 1 | Freezes the calendar while high |
| wrEn | input | 1 | Host write enable |
| wrAddr | input | 4 | Host write field select |
| wrData | input | 8 | Host write byte |
| secReg | output | 8 | Seconds byte |
| minReg | output | 8 | Minutes byte |
| hourReg | output | 8 | Hours byte |
| dowReg | output | 8 | Day-of-week byte |
| domReg | output | 8 | Day-of-month byte |
| monReg | output | 8 | Month byte |
| yearReg | output | 8 | Year byte (year modulo 100) |
| centReg | output | 8 | Century byte |
| ufPulse | output | 1 | Update-ended pulse |
| afPulse | output | 1 | Alarm-match pulse |

## Verification
The range assertions on the seconds and day-of-week bytes assume two things. First, the host only loads legal values for the selected encoding. Second, `binMode` and `hr24` do not change between a strobe and the cycle after it. The bench meets both conditions: it changes the format bits only while no strobe is pending, and after every format change it reloads all eight time fields with legal values encoded in the new format before it issues any strobe. Random times are drawn close to the minute, hour, day and year boundaries, so that carry chains occur often.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int BYTE_W      = 8;
  localparam int ADDR_W      = 4;
  localparam int NUM_TIME    = 8;
  localparam int NUM_ALARM   = 3;
  localparam int SEC_MAX     = 59;
  localparam int HOUR_MAX    = 23;
  localparam int DOW_MAX     = 7;
  localparam int MON_MAX     = 12;
  localparam int YEAR_MAX    = 99;

  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DOW  = 3;
  localparam int IDX_DOM  = 4;
  localparam int IDX_MON  = 5;
  localparam int IDX_YEAR = 6;
  localparam int IDX_CENT = 7;
  localparam int ALARM_BASE = NUM_TIME;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic              doAdvance;
    logic              doWrite;
    logic [ADDR_W-1:0] wrField;
  } ctlStrobe_t;

  function automatic byte_t byteToVal(input byte_t b, input logic bin);
    byte_t tens, ones;
    tens = {4'd0, b[7:4]};
    ones = {4'd0, b[3:0]};
    return bin ? {1'b0, b[6:0]} : (tens * 8'd10) + ones;
  endfunction

  function automatic byte_t valToByte(input byte_t v, input logic bin);
    byte_t t, u;
    t = v / 8'd10;
    u = v % 8'd10;
    return bin ? v : {t[3:0], u[3:0]};
  endfunction

  function automatic byte_t hourToVal(input byte_t b, input logic bin, input logic h24);
    byte_t h12;
    if (h24) return byteToVal(b, bin);
    h12 = byteToVal({1'b0, b[6:0]}, bin);
    if (h12 == 8'd12) return b[7] ? 8'd12 : 8'd0;
    return b[7] ? h12 + 8'd12 : h12;
  endfunction

  function automatic byte_t valToHour(input byte_t v, input logic bin, input logic h24);
    byte_t h12, enc;
    if (h24) return valToByte(v, bin);
    if (v == 8'd0)      h12 = 8'd12;
    else if (v > 8'd12) h12 = v - 8'd12;
    else                h12 = v;
    enc = valToByte(h12, bin);
    return {(v >= 8'd12), enc[6:0]};
  endfunction

  function automatic byte_t daysInMonth(input byte_t mon, input byte_t yr);
    case (mon)
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      8'd2:                    return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      default:                 return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickStrobe,
  input  logic              holdSet,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              alarmHit,
  output ctlStrobe_t        strobe,
  output logic              ufPulse,
  output logic              afPulse
);
  always_comb begin
    strobe.doWrite   = wrEn;
    strobe.wrField   = wrAddr;
    strobe.doAdvance = tickStrobe && !holdSet && !wrEn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ufPulse <= 1'b0;
      afPulse <= 1'b0;
    end else begin
      ufPulse <= strobe.doAdvance;
      afPulse <= strobe.doAdvance && alarmHit;
    end
  end
endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ctlStrobe_t strobe,
  input  byte_t      wrData,
  input  logic       binMode,
  input  logic       hr24,
  output byte_t      timeOut [NUM_TIME],
  output logic       alarmHit
);
  byte_t timeQ  [NUM_TIME];
  byte_t alarmQ [NUM_ALARM];
  byte_t nextTime [NUM_TIME];
  logic [NUM_ALARM-1:0] fieldHit;

  byte_t secV, minV, hourV, dowV, domV, monV, yearV, centV;
  byte_t secN, minN, hourN, dowN, domN, monN, yearN, centN;
  byte_t monthLen;
  logic  cMin, cHour, cDay, cMon, cYear;

  always_comb begin
    secV  = byteToVal(timeQ[IDX_SEC],  binMode);
    minV  = byteToVal(timeQ[IDX_MIN],  binMode);
    hourV = hourToVal(timeQ[IDX_HOUR], binMode, hr24);
    dowV  = byteToVal(timeQ[IDX_DOW],  binMode);
    domV  = byteToVal(timeQ[IDX_DOM],  binMode);
    monV  = byteToVal(timeQ[IDX_MON],  binMode);
    yearV = byteToVal(timeQ[IDX_YEAR], binMode);
    centV = byteToVal(timeQ[IDX_CENT], binMode);
    monthLen = daysInMonth(monV, yearV);

    cMin = (secV >= 8'(SEC_MAX));
    secN = cMin ? 8'd0 : secV + 8'd1;

    cHour = 1'b0;
    minN  = minV;
    if (cMin) begin
      cHour = (minV >= 8'(SEC_MAX));
      minN  = cHour ? 8'd0 : minV + 8'd1;
    end

    cDay  = 1'b0;
    hourN = hourV;
    if (cHour) begin
      cDay  = (hourV >= 8'(HOUR_MAX));
      hourN = cDay ? 8'd0 : hourV + 8'd1;
    end

    cMon = 1'b0;
    dowN = dowV;
    domN = domV;
    if (cDay) begin
      dowN = (dowV >= 8'(DOW_MAX)) ? 8'd1 : dowV + 8'd1;
      cMon = (domV >= monthLen);
      domN = cMon ? 8'd1 : domV + 8'd1;
    end

    cYear = 1'b0;
    monN  = monV;
    if (cMon) begin
      cYear = (monV >= 8'(MON_MAX));
      monN  = cYear ? 8'd1 : monV + 8'd1;
    end

    yearN = yearV;
    centN = centV;
    if (cYear) begin
      if (yearV >= 8'(YEAR_MAX)) begin
        yearN = 8'd0;
        centN = (centV >= 8'(YEAR_MAX)) ? 8'd0 : centV + 8'd1;
      end else begin
        yearN = yearV + 8'd1;
      end
    end

    nextTime[IDX_SEC]  = valToByte(secN,  binMode);
    nextTime[IDX_MIN]  = valToByte(minN,  binMode);
    nextTime[IDX_HOUR] = valToHour(hourN, binMode, hr24);
    nextTime[IDX_DOW]  = valToByte(dowN,  binMode);
    nextTime[IDX_DOM]  = valToByte(domN,  binMode);
    nextTime[IDX_MON]  = valToByte(monN,  binMode);
    nextTime[IDX_YEAR] = valToByte(yearN, binMode);
    nextTime[IDX_CENT] = valToByte(centN, binMode);
  end

  for (genvar i = 0; i < NUM_ALARM; i++) begin : g_alarmCmp
    assign fieldHit[i] = (alarmQ[i][7:6] == 2'b11) || (alarmQ[i] == nextTime[i]);
  end
  assign alarmHit = &fieldHit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_TIME; k++) timeQ[k] <= '0;
      timeQ[IDX_DOW]  <= 8'h01;
      timeQ[IDX_DOM]  <= 8'h01;
      timeQ[IDX_MON]  <= 8'h01;
      timeQ[IDX_CENT] <= 8'h20;
      for (int k = 0; k < NUM_ALARM; k++) alarmQ[k] <= '0;
    end else if (strobe.doWrite) begin
      for (int k = 0; k < NUM_TIME; k++)
        if (strobe.wrField == ADDR_W'(k)) timeQ[k] <= wrData;
      for (int k = 0; k < NUM_ALARM; k++)
        if (strobe.wrField == ADDR_W'(ALARM_BASE + k)) alarmQ[k] <= wrData;
    end else if (strobe.doAdvance) begin
      for (int k = 0; k < NUM_TIME; k++) timeQ[k] <= nextTime[k];
    end
  end

  assign timeOut = timeQ;

  assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.doWrite && strobe.wrField == ADDR_W'(IDX_SEC)) |=> (timeQ[IDX_SEC] == $past(wrData)));

  assert_sec_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.doAdvance |=> (binMode ? (timeQ[IDX_SEC] < 8'd60)
                                  : (timeQ[IDX_SEC][3:0] <= 4'd9 && timeQ[IDX_SEC][7:4] <= 4'd5)));

  assert_dow_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.doAdvance |=> (byteToVal(timeQ[IDX_DOW], binMode) >= 8'd1 &&
                          byteToVal(timeQ[IDX_DOW], binMode) <= 8'd7));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tickStrobe,
  input  logic       binMode,
  input  logic       hr24,
  input  logic       holdSet,
  input  logic       wrEn,
  input  logic [3:0] wrAddr,
  input  logic [7:0] wrData,
  output logic [7:0] secReg,
  output logic [7:0] minReg,
  output logic [7:0] hourReg,
  output logic [7:0] dowReg,
  output logic [7:0] domReg,
  output logic [7:0] monReg,
  output logic [7:0] yearReg,
  output logic [7:0] centReg,
  output logic       ufPulse,
  output logic       afPulse
);
  ctlStrobe_t strobe;
  logic       alarmHit;
  byte_t      timeOut [NUM_TIME];

  rtc_cal_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tickStrobe(tickStrobe), .holdSet(holdSet),
    .wrEn(wrEn), .wrAddr(wrAddr), .alarmHit(alarmHit),
    .strobe(strobe), .ufPulse(ufPulse), .afPulse(afPulse)
  );

  rtc_cal_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(wrData),
    .binMode(binMode), .hr24(hr24), .timeOut(timeOut), .alarmHit(alarmHit)
  );

  assign secReg  = timeOut[IDX_SEC];
  assign minReg  = timeOut[IDX_MIN];
  assign hourReg = timeOut[IDX_HOUR];
  assign dowReg  = timeOut[IDX_DOW];
  assign domReg  = timeOut[IDX_DOM];
  assign monReg  = timeOut[IDX_MON];
  assign yearReg = timeOut[IDX_YEAR];
  assign centReg = timeOut[IDX_CENT];

  assert_uf_follows_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ufPulse |-> $past(tickStrobe && !holdSet && !wrEn));

  assert_hold_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (holdSet && !wrEn) |=> $stable({secReg, minReg, hourReg, dowReg, domReg, monReg, yearReg, centReg}));
endmodule

// File: tb/tb_rtc_calendar.sv
module tb_rtc_calendar;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tickStrobe = 1'b0, binMode = 1'b0, hr24 = 1'b1, holdSet = 1'b0, wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] secReg, minReg, hourReg, dowReg, domReg, monReg, yearReg, centReg;
  logic ufPulse, afPulse;

  int testCount = 0, failCount = 0;
  bit done = 1'b0;

  int mSec, mMin, mHour, mDow, mDom, mMon, mYear, mCent;
  logic [7:0] aByte [3];
  logic expAf;

  always #4 clk = ~clk;

  rtc_calendar dut (
    .clk(clk), .rst_n(rst_n), .tickStrobe(tickStrobe), .binMode(binMode), .hr24(hr24),
    .holdSet(holdSet), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .secReg(secReg), .minReg(minReg), .hourReg(hourReg), .dowReg(dowReg), .domReg(domReg),
    .monReg(monReg), .yearReg(yearReg), .centReg(centReg), .ufPulse(ufPulse), .afPulse(afPulse)
  );

  function automatic logic [7:0] enc(int v, logic bin);
    return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] encH(int h, logic bin, logic h24);
    int h12;
    if (h24) return enc(h, bin);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return (h >= 12 ? 8'h80 : 8'h00) | enc(h12, bin);
  endfunction

  function automatic int dim(int m, int y);
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    return 31;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic modelAdvance();
    logic [7:0] s, mi, h;
    mSec++;
    if (mSec == 60) begin
      mSec = 0; mMin++;
      if (mMin == 60) begin
        mMin = 0; mHour++;
        if (mHour == 24) begin
          mHour = 0;
          mDow = (mDow == 7) ? 1 : mDow + 1;
          if (mDom >= dim(mMon, mYear)) begin
            mDom = 1; mMon++;
            if (mMon == 13) begin
              mMon = 1; mYear++;
              if (mYear == 100) begin mYear = 0; mCent = (mCent + 1) % 100; end
            end
          end else mDom++;
        end
      end
    end
    s = enc(mSec, binMode); mi = enc(mMin, binMode); h = encH(mHour, binMode, hr24);
    expAf = (aByte[0][7:6] == 2'b11 || aByte[0] == s) &&
            (aByte[1][7:6] == 2'b11 || aByte[1] == mi) &&
            (aByte[2][7:6] == 2'b11 || aByte[2] == h);
  endtask

  task automatic checkAll(string req, logic expUf, logic expAfv);
    chk(req, secReg,  enc(mSec, binMode));
    chk(req, minReg,  enc(mMin, binMode));
    chk(req, hourReg, encH(mHour, binMode, hr24));
    chk(req, dowReg,  enc(mDow, binMode));
    chk(req, domReg,  enc(mDom, binMode));
    chk(req, monReg,  enc(mMon, binMode));
    chk(req, yearReg, enc(mYear, binMode));
    chk(req, centReg, enc(mCent, binMode));
    chk({req, " uf"}, 8'(ufPulse), 8'(expUf));
    chk({req, " af"}, 8'(afPulse), 8'(expAfv));
  endtask

  task automatic wr(int addr, logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'(addr); wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setAlarm(int idx, logic [7:0] b);
    aByte[idx] = b;
    wr(8 + idx, b);
  endtask

  task automatic loadTime();
    wr(0, enc(mSec, binMode));  wr(1, enc(mMin, binMode));
    wr(2, encH(mHour, binMode, hr24)); wr(3, enc(mDow, binMode));
    wr(4, enc(mDom, binMode));  wr(5, enc(mMon, binMode));
    wr(6, enc(mYear, binMode)); wr(7, enc(mCent, binMode));
  endtask

  task automatic setTime(int h, int mi, int s, int dw, int d, int mo, int y, int c);
    mHour = h; mMin = mi; mSec = s; mDow = dw; mDom = d; mMon = mo; mYear = y; mCent = c;
    loadTime();
  endtask

  task automatic tick();
    @(negedge clk);
    tickStrobe = 1'b1;
    @(negedge clk);
    tickStrobe = 1'b0;
  endtask

  task automatic stepCheck(string req);
    modelAdvance();
    tick();
    checkAll(req, 1'b1, expAf);
  endtask

  task automatic setMode(logic bin, logic h24);
    @(negedge clk);
    binMode = bin; hr24 = h24;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      testCount++; failCount++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    for (int i = 0; i < 3; i++) aByte[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    mSec = 0; mMin = 0; mHour = 0; mDow = 1; mDom = 1; mMon = 1; mYear = 0; mCent = 20;
    checkAll("R1", 1'b0, 1'b0);

    // R2 BCD and binary seconds
    setTime(10, 15, 9, 3, 12, 6, 21, 20);
    stepCheck("R2");
    chk("R2 bcd", secReg, 8'h10);
    setMode(1'b1, 1'b1);
    setTime(10, 15, 9, 3, 12, 6, 21, 20);
    stepCheck("R2");
    chk("R2 bin", secReg, 8'h0A);

    // R3 R5 R6 full rollover in BCD
    setMode(1'b0, 1'b1);
    setTime(23, 59, 59, 7, 31, 12, 99, 20);
    stepCheck("R3 R6");
    chk("R3", minReg, 8'h00);
    chk("R4", hourReg, 8'h00);
    chk("R6 dow", dowReg, 8'h01);
    chk("R5", domReg, 8'h01);
    chk("R6 mon", monReg, 8'h01);
    chk("R6 year", yearReg, 8'h00);
    chk("R6 cent", centReg, 8'h21);

    // R5 month lengths
    setTime(23, 59, 59, 2, 28, 2, 24, 20);
    stepCheck("R5");
    chk("R5 leap", domReg, 8'h29);
    setTime(23, 59, 59, 2, 28, 2, 23, 20);
    stepCheck("R5");
    chk("R5 nonleap", monReg, 8'h03);
    setTime(23, 59, 59, 2, 29, 2, 24, 20);
    stepCheck("R5");
    chk("R5 leap end", domReg, 8'h01);
    setTime(23, 59, 59, 2, 30, 4, 24, 20);
    stepCheck("R5");
    chk("R5 30day", monReg, 8'h05);

    // R4 12-hour mode
    setMode(1'b0, 1'b0);
    setTime(11, 59, 59, 1, 5, 5, 5, 20);
    stepCheck("R4");
    chk("R4 noon", hourReg, 8'h92);
    setTime(12, 59, 59, 1, 5, 5, 5, 20);
    stepCheck("R4");
    chk("R4 1pm", hourReg, 8'h81);
    setTime(23, 59, 59, 1, 5, 5, 5, 20);
    stepCheck("R4");
    chk("R4 midnight", hourReg, 8'h12);
    chk("R4 daycarry", domReg, 8'h06);
    setMode(1'b1, 1'b0);
    setTime(11, 59, 59, 1, 5, 5, 5, 20);
    stepCheck("R4");
    chk("R4 bin noon", hourReg, 8'h8C);

    // R8 R9 alarm
    setMode(1'b0, 1'b1);
    setTime(10, 20, 29, 1, 5, 5, 5, 20);
    setAlarm(0, 8'h30); setAlarm(1, 8'h20); setAlarm(2, 8'h10);
    stepCheck("R9 match");
    chk("R9 hit", 8'(afPulse), 8'h01);
    chk("R8 uf", 8'(ufPulse), 8'h01);
    @(negedge clk);
    chk("R8 uf one cycle", 8'(ufPulse), 8'h00);
    chk("R9 af one cycle", 8'(afPulse), 8'h00);
    setTime(10, 20, 29, 1, 5, 5, 5, 20);
    setAlarm(2, 8'h11);
    stepCheck("R9 miss");
    chk("R9 miss", 8'(afPulse), 8'h00);
    setTime(10, 20, 29, 1, 5, 5, 5, 20);
    setAlarm(2, 8'hC5);
    stepCheck("R9 wildcard");
    chk("R9 wild", 8'(afPulse), 8'h01);

    // R7 hold
    @(negedge clk); holdSet = 1'b1;
    tick();
    checkAll("R7 hold", 1'b0, 1'b0);
    mSec = 33;
    wr(0, enc(mSec, binMode));
    tick();
    checkAll("R7 write held", 1'b0, 1'b0);
    @(negedge clk); holdSet = 1'b0;

    // R10 write beats strobe
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd1; wrData = 8'h44; tickStrobe = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tickStrobe = 1'b0;
    mMin = 44;
    checkAll("R10", 1'b0, 1'b0);

    // R11 unused address
    wr(13, 8'h55);
    checkAll("R11 ignored", 1'b0, 1'b0);
    stepCheck("R11 after ignored");

    // Random phase
    for (int it = 0; it < 60; it++) begin
      int nTicks;
      setMode(1'($urandom % 2), 1'($urandom % 2));
      mSec = 50 + $urandom % 10;
      mMin = ($urandom % 2) ? 59 : $urandom % 60;
      mHour = ($urandom % 2) ? 23 : $urandom % 24;
      mDow = 1 + $urandom % 7;
      mMon = 1 + $urandom % 12;
      mYear = ($urandom % 4 == 0) ? 99 : $urandom % 100;
      mDom = dim(mMon, mYear) - ($urandom % 2);
      mCent = $urandom % 100;
      loadTime();
      setAlarm(0, ($urandom % 2) ? (8'hC0 | 8'($urandom % 64)) : enc((mSec + 1 + $urandom % 3) % 60, binMode));
      setAlarm(1, ($urandom % 2) ? 8'hC0 : enc(mMin, binMode));
      setAlarm(2, ($urandom % 2) ? 8'hC0 : encH(mHour, binMode, hr24));
      nTicks = 1 + $urandom % 6;
      for (int t = 0; t < nTicks; t++) stepCheck("R3 R4 R5 R6 R9 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule